// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block walks through a window of interrupt IDs, one ID per clock, and keeps for each of a few CPUs the most urgent pending interrupt that targets it. For every interrupt the surrounding logic provides an eligibility bit, an 8-bit priority, a target-CPU index with a valid flag and a 2-bit group code. For every CPU the block reports the ID, the priority and the group of the current winner. A priority of 0xFF in a CPU's result slot means that nothing is pending for that CPU.

Two kinds of pass exist. A full pass discards every CPU's winner and looks at all interrupts. A partial pass looks only at `len` IDs starting at `base` and compares them against the winners already held. A partial pass can fail to see a CPU's winner again even though that winner lies inside the window. This happens when the winner lost urgency or stopped pending. In that case the block follows on with a full pass by itself, because any other interrupt could now be the best one. The results seen at the ports change only on the cycle that `done` pulses.

Top module: `hppi_select`

## Requirements
- R1: Interrupt i uses `prio_vec[8i+7:8i]`, `tgt_vec[i*CPUW+CPUW-1:i*CPUW]` (CPUW = max(1, log2 N_CPU)), `tgt_vld[i]`, `elig[i]` and `grp_vec[2i+1:2i]`. CPU c reports in slot c of `win_id` (IDW bits each), `win_prio` (8 bits) and `win_grp` (2 bits). Among the eligible interrupts aimed at one CPU, the numerically smaller priority wins.
- R2: When two candidates have equal priority, the lower ID wins.
- R3: A candidate with the same priority and the same ID as the held winner counts as better. A partial pass over the winner's own ID therefore keeps that winner, refreshes its group from `grp_vec` and triggers no follow-on full pass.
- R4: After reset every CPU slot reports priority 0xFF, and `busy` and `done` are low. A CPU with no candidate after a full pass reports priority 0xFF.
- R5: A full pass (`full_req`=1 at launch) first sets every CPU's priority to 0xFF and then visits all N_IRQ IDs. `done` rises N_IRQ+1 cycles after the launching edge.
- R6: An eligible interrupt is skipped when its `tgt_vld` is low or its target index is N_CPU or more.
- R7: After a partial pass, if any CPU recorded no new winner, still holds a priority other than 0xFF, and holds a winner ID inside [base, base+len), a full pass follows. `done` then rises len+N_IRQ+2 cycles after launch.
- R8: A CPU's reported group changes only when the pass records a new winner for that CPU. A group input change on a winner the pass does not revisit is not reflected.
- R9: `win_id`, `win_prio` and `win_grp` hold steady on every cycle except the one where `done` is high. `done` is a one-cycle pulse. `busy` is high from the launch edge until `done` rises and is low in the `done` cycle.
- R10: A `start` while `busy` is high is ignored. It changes neither the timing nor the outcome of the pass in progress.
- R11: A partial pass visits IDs base to base+len-1. Without a follow-on full pass, `done` rises len+1 cycles after launch.
- R12: IDs of N_IRQ or more inside a partial window contribute nothing. A partial pass with len 0 finishes one cycle after launch and leaves all results unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a pass when the block is idle |
| full_req | input | 1 | 1 selects a full pass, 0 a partial pass |
| base | input | IDW | First ID of a partial window |
| len | input | IDW+1 | Number of IDs in a partial window |
| elig | input | N_IRQ | Per-interrupt eligibility |
| prio_vec | input | 8*N_IRQ | Per-interrupt priority, 8 bits each |
| tgt_vec | input | CPUW*N_IRQ | Per-interrupt target CPU index |
| tgt_vld | input | N_IRQ | Per-interrupt target valid flag |
| grp_vec | input | 2*N_IRQ | Per-interrupt group code |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| win_id | output | IDW*N_CPU | Winner ID per CPU |
| win_prio | output | 8*N_CPU | Winner priority per CPU, 0xFF when none |
| win_grp | output | 2*N_CPU | Winner group per CPU |

## Verification
A launch is sampled on one edge. `busy` follows one cycle later, and results together with `done` come len+1, N_IRQ+1 or len+N_IRQ+2 cycles after that edge, depending on the kind of pass and whether a full pass follows. The bench counts edges from the launch to the first falling-edge sample that shows `done`, and compares that count with the expected latency. A behavioural model advances on the same edges with a countdown of the expected latency. Its `done`, `busy` and per-CPU results are compared with the ports at every falling edge, so a result that arrives a cycle early or late, or that changes outside the `done` cycle, shows up as a mismatch.

// File: rtl/hppi_pkg.sv
package hppi_pkg;

    localparam int PRIO_W = 8;
    localparam int GRP_W  = 2;
    localparam logic [PRIO_W-1:0] PRIO_NONE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_CHECK = 2'd2
    } scan_state_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic [GRP_W-1:0]  grp;
    } win_attr_t;

    // Candidate beats the held best when it is more urgent, or equally
    // urgent with an ID no larger (equal ID counts as a win).
    function automatic logic prio_beats(
        input logic [PRIO_W-1:0] cand_prio,
        input logic [15:0]       cand_id,
        input logic [PRIO_W-1:0] best_prio,
        input logic [15:0]       best_id
    );
        return (cand_prio < best_prio) ||
               ((cand_prio == best_prio) && (cand_id <= best_id));
    endfunction

endpackage

// File: rtl/hppi_scan_ctrl.sv
module hppi_scan_ctrl
    import hppi_pkg::*;
#(
    parameter int N_IRQ = 64,
    parameter int CNTW  = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            full_req,
    input  logic [CNTW-1:0] base,
    input  logic [CNTW-1:0] len,
    input  logic            escalate,
    output logic            busy,
    output logic            scanning,
    output logic [CNTW-1:0] cur,
    output logic            seen_clr,
    output logic            prio_clr,
    output logic            commit,
    output logic [CNTW-1:0] rng_lo,
    output logic [CNTW-1:0] rng_hi
);
    localparam logic [CNTW-1:0] N_CNT = CNTW'(N_IRQ);

    scan_state_e     state;
    logic            full_mode;
    logic [CNTW-1:0] rem;
    logic            go_full;

    assign go_full  = (state == ST_CHECK) && escalate && !full_mode;
    assign busy     = (state != ST_IDLE);
    assign scanning = (state == ST_SCAN);
    assign commit   = (state == ST_CHECK) && !go_full;
    assign seen_clr = ((state == ST_IDLE) && start) || go_full;
    assign prio_clr = ((state == ST_IDLE) && start && full_req) || go_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            full_mode <= 1'b0;
            cur       <= '0;
            rem       <= '0;
            rng_lo    <= '0;
            rng_hi    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        full_mode <= full_req;
                        cur       <= full_req ? '0 : base;
                        rem       <= full_req ? N_CNT : len;
                        rng_lo    <= base;
                        rng_hi    <= base + len;
                        state     <= (full_req || (len != '0)) ? ST_SCAN : ST_CHECK;
                    end
                end
                ST_SCAN: begin
                    cur <= cur + 1'b1;
                    rem <= rem - 1'b1;
                    if (rem == CNTW'(1)) begin
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (go_full) begin
                        full_mode <= 1'b1;
                        cur       <= '0;
                        rem       <= N_CNT;
                        state     <= ST_SCAN;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hppi_cpu_track.sv
module hppi_cpu_track
    import hppi_pkg::*;
#(
    parameter int IDW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seen_clr,
    input  logic              prio_clr,
    input  logic              hit,
    input  logic [IDW-1:0]    cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [GRP_W-1:0]  cand_grp,
    input  logic              commit,
    output logic [IDW-1:0]    wk_id,
    output logic [PRIO_W-1:0] wk_prio,
    output logic              seen,
    output logic [IDW-1:0]    out_id,
    output win_attr_t         out_attr
);
    win_attr_t wk_attr;
    logic      better;

    assign wk_prio = wk_attr.prio;
    assign better  = hit && prio_beats(cand_prio, 16'(cand_id), wk_attr.prio, 16'(wk_id));

    always_ff @(posedge clk) begin
        if (rst) begin
            wk_id    <= '0;
            wk_attr  <= '{prio: PRIO_NONE, grp: '0};
            seen     <= 1'b0;
            out_id   <= '0;
            out_attr <= '{prio: PRIO_NONE, grp: '0};
        end else begin
            if (seen_clr) begin
                seen <= 1'b0;
                if (prio_clr) begin
                    wk_attr.prio <= PRIO_NONE;
                end
            end else if (better) begin
                wk_id   <= cand_id;
                wk_attr <= '{prio: cand_prio, grp: cand_grp};
                seen    <= 1'b1;
            end
            if (commit) begin
                out_id   <= wk_id;
                out_attr <= wk_attr;
            end
        end
    end

endmodule

// File: rtl/hppi_select.sv
module hppi_select
    import hppi_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int N_IRQ = 64,
    localparam int IDW  = $clog2(N_IRQ),
    localparam int CNTW = IDW + 1,
    localparam int CPUW = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      full_req,
    input  logic [IDW-1:0]            base,
    input  logic [CNTW-1:0]           len,
    input  logic [N_IRQ-1:0]          elig,
    input  logic [N_IRQ*PRIO_W-1:0]   prio_vec,
    input  logic [N_IRQ*CPUW-1:0]     tgt_vec,
    input  logic [N_IRQ-1:0]          tgt_vld,
    input  logic [N_IRQ*GRP_W-1:0]    grp_vec,
    output logic                      busy,
    output logic                      done,
    output logic [N_CPU*IDW-1:0]      win_id,
    output logic [N_CPU*PRIO_W-1:0]   win_prio,
    output logic [N_CPU*GRP_W-1:0]    win_grp
);
    logic              scanning, seen_clr, prio_clr, commit, escalate;
    logic [CNTW-1:0]   cur, rng_lo, rng_hi;
    logic [IDW-1:0]    idx;
    logic              in_bnd, tgt_in, cand_ok;
    logic [CPUW-1:0]   cand_tgt;
    logic [PRIO_W-1:0] cand_prio;
    logic [GRP_W-1:0]  cand_grp;
    logic [N_CPU-1:0]  need;

    hppi_scan_ctrl #(.N_IRQ(N_IRQ), .CNTW(CNTW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .full_req (full_req),
        .base     ({1'b0, base}),
        .len      (len),
        .escalate (escalate),
        .busy     (busy),
        .scanning (scanning),
        .cur      (cur),
        .seen_clr (seen_clr),
        .prio_clr (prio_clr),
        .commit   (commit),
        .rng_lo   (rng_lo),
        .rng_hi   (rng_hi)
    );

    // Candidate fetch for the ID under the cursor
    assign idx       = cur[IDW-1:0];
    assign in_bnd    = (cur < CNTW'(N_IRQ));
    assign cand_tgt  = tgt_vec[idx*CPUW +: CPUW];
    assign cand_prio = prio_vec[idx*PRIO_W +: PRIO_W];
    assign cand_grp  = grp_vec[idx*GRP_W +: GRP_W];

    generate
        if (N_CPU == (1 << CPUW)) begin : g_tgt_full
            assign tgt_in = 1'b1;
        end else begin : g_tgt_part
            assign tgt_in = (32'(cand_tgt) < N_CPU);
        end
    endgenerate

    assign cand_ok  = scanning && in_bnd && elig[idx] && tgt_vld[idx] && tgt_in;
    assign escalate = |need;

    generate
        for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
            logic [IDW-1:0]    wk_id;
            logic [PRIO_W-1:0] wk_prio;
            logic              seen;
            logic [IDW-1:0]    out_id;
            win_attr_t         out_attr;

            hppi_cpu_track #(.IDW(IDW)) u_trk (
                .clk       (clk),
                .rst       (rst),
                .seen_clr  (seen_clr),
                .prio_clr  (prio_clr),
                .hit       (cand_ok && (cand_tgt == CPUW'(c))),
                .cand_id   (idx),
                .cand_prio (cand_prio),
                .cand_grp  (cand_grp),
                .commit    (commit),
                .wk_id     (wk_id),
                .wk_prio   (wk_prio),
                .seen      (seen),
                .out_id    (out_id),
                .out_attr  (out_attr)
            );

            // Held winner lost inside the window without a replacement
            assign need[c] = !seen && (wk_prio != PRIO_NONE) &&
                             ({1'b0, wk_id} >= rng_lo) && ({1'b0, wk_id} < rng_hi);

            assign win_id[c*IDW +: IDW]       = out_id;
            assign win_prio[c*PRIO_W +: PRIO_W] = out_attr.prio;
            assign win_grp[c*GRP_W +: GRP_W]  = out_attr.grp;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else begin
            done <= commit;
        end
    end

endmodule

// File: rtl/hppi_select_chk.sv
module hppi_select_chk #(
    parameter int N_CPU = 4,
    parameter int N_IRQ = 64,
    localparam int IDW  = $clog2(N_IRQ)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic [N_CPU*IDW-1:0]  win_id,
    input logic [N_CPU*8-1:0]    win_prio,
    input logic [N_CPU*2-1:0]    win_grp
);
    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: results move only in the done cycle
    p_hold_results_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(win_id) && $stable(win_prio) && $stable(win_grp)));

    // R9: busy drops exactly when the pass completes
    p_busy_ends_at_done_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9: done cycle reports idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10: an idle start always launches a pass
    p_launch_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R10: busy only rises from an accepted start
    p_busy_source_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

bind hppi_select hppi_select_chk #(.N_CPU(N_CPU), .N_IRQ(N_IRQ)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .win_id   (win_id),
    .win_prio (win_prio),
    .win_grp  (win_grp)
);

// File: tb/hppi_select_test.sv
module hppi_select_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_CPU = 4;
    localparam int N_IRQ = 64;
    localparam int IDW   = $clog2(N_IRQ);
    localparam int CNTW  = IDW + 1;
    localparam int CPUW  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic full_req = 1'b0;
    logic [IDW-1:0] base = '0;
    logic [CNTW-1:0] len = '0;
    logic [N_IRQ-1:0] elig = '0;
    logic [N_IRQ*8-1:0] prio_vec = '0;
    logic [N_IRQ*CPUW-1:0] tgt_vec = '0;
    logic [N_IRQ-1:0] tgt_vld = '0;
    logic [N_IRQ*2-1:0] grp_vec = '0;
    logic busy, done;
    logic [N_CPU*IDW-1:0] win_id;
    logic [N_CPU*8-1:0] win_prio;
    logic [N_CPU*2-1:0] win_grp;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string phase = "R4";

    hppi_select #(.N_CPU(N_CPU), .N_IRQ(N_IRQ)) uut (
        .clk(clk), .rst(rst), .start(start), .full_req(full_req),
        .base(base), .len(len), .elig(elig), .prio_vec(prio_vec),
        .tgt_vec(tgt_vec), .tgt_vld(tgt_vld), .grp_vec(grp_vec),
        .busy(busy), .done(done), .win_id(win_id), .win_prio(win_prio),
        .win_grp(win_grp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int  m_wid[N_CPU], m_wprio[N_CPU], m_wgrp[N_CPU];
    int  m_oid[N_CPU], m_oprio[N_CPU], m_ogrp[N_CPU];
    bit  m_seen[N_CPU];
    bit  m_busy, m_done;
    int  m_cnt;

    task automatic model_pass(input int lo, input int cnt);
        for (int i = lo; i < lo + cnt; i++) begin
            if (i < N_IRQ && elig[i] && tgt_vld[i] && int'(tgt_vec[i*CPUW +: CPUW]) < N_CPU) begin
                int c, p;
                c = int'(tgt_vec[i*CPUW +: CPUW]);
                p = int'(prio_vec[i*8 +: 8]);
                if (p < m_wprio[c] || (p == m_wprio[c] && i <= m_wid[c])) begin
                    m_wid[c] = i; m_wprio[c] = p;
                    m_wgrp[c] = int'(grp_vec[i*2 +: 2]);
                    m_seen[c] = 1'b1;
                end
            end
        end
    endtask

    task automatic model_full();
        for (int c = 0; c < N_CPU; c++) begin m_wprio[c] = 255; m_seen[c] = 1'b0; end
        model_pass(0, N_IRQ);
    endtask

    task automatic model_launch(input bit f, input int b, input int l, output int d);
        if (f) begin
            model_full();
            d = N_IRQ + 1;
        end else begin
            bit esc;
            esc = 1'b0;
            for (int c = 0; c < N_CPU; c++) m_seen[c] = 1'b0;
            model_pass(b, l);
            d = l + 1;
            for (int c = 0; c < N_CPU; c++)
                if (!m_seen[c] && m_wprio[c] != 255 && m_wid[c] >= b && m_wid[c] < b + l) esc = 1'b1;
            if (esc) begin
                model_full();
                d = d + N_IRQ + 1;
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N_CPU; c++) begin
                m_wid[c] = 0; m_wprio[c] = 255; m_wgrp[c] = 0;
                m_oid[c] = 0; m_oprio[c] = 255; m_ogrp[c] = 0;
            end
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0;
        end else if (m_busy) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                for (int c = 0; c < N_CPU; c++) begin
                    m_oid[c] = m_wid[c]; m_oprio[c] = m_wprio[c]; m_ogrp[c] = m_wgrp[c];
                end
                m_done = 1'b1; m_busy = 1'b0;
            end else begin
                m_done = 1'b0;
            end
        end else begin
            m_done = 1'b0;
            if (start) begin
                int d;
                model_launch(full_req, int'(base), int'(len), d);
                m_busy = 1'b1; m_cnt = d;
            end
        end
    end

    // R9: per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            bit bad;
            bad = (done !== m_done) || (busy !== m_busy);
            for (int c = 0; c < N_CPU; c++) begin
                if (int'(win_prio[c*8 +: 8]) != m_oprio[c] || win_prio[c*8 +: 8] === 'x) bad = 1'b1;
                if (m_oprio[c] != 255 && (int'(win_id[c*IDW +: IDW]) != m_oid[c] ||
                                          int'(win_grp[c*2 +: 2]) != m_ogrp[c])) bad = 1'b1;
            end
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL R9 (%s) cycle %0d: done=%0b busy=%0b prio=%h id=%h grp=%h expected done=%0b busy=%0b prio0=%0d id0=%0d",
                         phase, cycles, done, busy, win_prio, win_id, win_grp, m_done, m_busy, m_oprio[0], m_oid[0]);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_irq(input int i, input bit e, input int p, input int t, input bit v, input int g);
        elig[i] = e;
        prio_vec[i*8 +: 8] = 8'(p);
        tgt_vec[i*CPUW +: CPUW] = CPUW'(t);
        tgt_vld[i] = v;
        grp_vec[i*2 +: 2] = 2'(g);
    endtask

    // Launch a pass; return the edge count from launch to the done sample.
    // inj > 0 drives a stray start during that busy cycle.
    task automatic run_pass(input bit f, input int b, input int l, input int inj, output int n);
        @(negedge clk);
        full_req = f; base = IDW'(b); len = CNTW'(l); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = (n == inj);
            if (n == inj) begin full_req = 1'b0; base = '0; len = CNTW'(1); end
        end while (!done && n < 2000);
        start = 1'b0;
    endtask

    function automatic int pr(input int c); return int'(win_prio[c*8 +: 8]); endfunction
    function automatic int wid(input int c); return int'(win_id[c*IDW +: IDW]); endfunction
    function automatic int wgr(input int c); return int'(win_grp[c*2 +: 2]); endfunction

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL R9 watchdog expired: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int n;
        for (int i = 0; i < N_IRQ; i++) set_irq(i, 1'b0, 8'hA0, 0, 1'b1, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R4: reset state
        for (int c = 0; c < N_CPU; c++) chk("R4", "reset priority", pr(c), 255);
        chk("R4", "reset busy", int'(busy), 0);
        chk("R4", "reset done", int'(done), 0);

        // Full pass
        phase = "R5";
        set_irq(10, 1, 8'h40, 0, 1, 1);
        set_irq(5,  1, 8'h80, 0, 1, 0);
        set_irq(20, 1, 8'h30, 1, 1, 2);
        set_irq(40, 1, 8'h30, 1, 1, 1);
        set_irq(7,  1, 8'h01, 2, 0, 0);
        set_irq(30, 1, 8'h50, 2, 1, 3);
        run_pass(1, 0, 0, 0, n);
        chk("R5", "full pass latency", n, N_IRQ + 1);
        chk("R1", "cpu0 winner id", wid(0), 10);
        chk("R1", "cpu0 winner prio", pr(0), 8'h40);
        chk("R2", "cpu1 tie winner id", wid(1), 20);
        chk("R6", "cpu2 winner skips no-target id", wid(2), 30);
        chk("R6", "cpu2 winner prio", pr(2), 8'h50);
        chk("R4", "cpu3 none", pr(3), 255);
        chk("R9", "busy low at done", int'(busy), 0);

        // R10: stray start during a pass
        phase = "R10";
        run_pass(1, 0, 0, 10, n);
        chk("R10", "latency with stray start", n, N_IRQ + 1);
        chk("R10", "cpu0 id unchanged", wid(0), 10);
        repeat (4) begin
            @(negedge clk);
            chk("R10", "no second pass busy", int'(busy), 0);
            chk("R10", "no second pass done", int'(done), 0);
        end

        // R11: partial pass with a new winner
        phase = "R11";
        set_irq(3, 1, 8'h10, 0, 1, 0);
        run_pass(0, 0, 8, 0, n);
        chk("R11", "partial latency", n, 9);
        chk("R11", "cpu0 new winner", wid(0), 3);
        chk("R11", "cpu1 untouched", wid(1), 20);

        // R8: group of an unrevisited winner
        phase = "R8";
        grp_vec[20*2 +: 2] = 2'd0;
        run_pass(0, 0, 8, 0, n);
        chk("R8", "cpu1 group held", wgr(1), 2);
        chk("R8", "no escalation latency", n, 9);

        // R3: rescanning the winner itself
        phase = "R3";
        grp_vec[3*2 +: 2] = 2'd3;
        run_pass(0, 3, 1, 0, n);
        chk("R3", "self rescan latency", n, 2);
        chk("R3", "winner kept", wid(0), 3);
        chk("R3", "group refreshed", wgr(0), 3);

        // R7: winner loses urgency inside the window
        phase = "R7";
        prio_vec[3*8 +: 8] = 8'h90;
        run_pass(0, 0, 8, 0, n);
        chk("R7", "escalated latency", n, 8 + N_IRQ + 2);
        chk("R7", "cpu0 recomputed id", wid(0), 10);
        chk("R7", "cpu0 recomputed prio", pr(0), 8'h40);
        chk("R7", "cpu1 group after full pass", wgr(1), 0);

        // R12: window past the last ID, then empty window
        phase = "R12";
        set_irq(62, 1, 8'h05, 3, 1, 1);
        run_pass(0, 60, 10, 0, n);
        chk("R12", "clipped window latency", n, 11);
        chk("R12", "cpu3 winner", wid(3), 62);
        chk("R12", "cpu3 prio", pr(3), 5);
        run_pass(0, 5, 0, 0, n);
        chk("R12", "empty window latency", n, 1);
        chk("R12", "cpu0 unchanged", wid(0), 10);
        chk("R12", "cpu3 unchanged", pr(3), 5);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule